// File: doc/BRIEF.md
# Camera Frame Timing Statistics Unit

This unit sits beside a camera capture channel and measures how the incoming video is timed. A free-running reference tick drives a live interval counter. Each frame boundary event (frame done or vsync) stores that counter as the length of the frame just ended and restarts it. The same event also increments an accumulator that software clears once per frame-done interrupt. A reading above one at that point means a frame went by without being serviced.

Across each frame the unit also tracks two peaks: the highest capture FIFO occupancy it sees, and the largest number of qualified pixel clocks counted within any single line. Both peaks are stored at the frame boundary and then start again. Software reads the results through a simple register port. The live counter sits next to the accumulator so that, inside the frame-done handler, software can judge whether there is still time to update double-buffered addresses.

Top module: `cam_frame_stats`

## Requirements
- R1: After reset, every register reads 0.
- R2: The live counter (bits 23:0 at offset 0x94) increases by one for each cycle with `ref_tick` high and no frame event. It holds otherwise and stops at all-ones instead of wrapping.
- R3: On a cycle with `frame_evt` high, the interval field (bits 23:0 at offset 0x90) takes the live counter's value from before that edge, and the live counter reads 0 on the next cycle.
- R4: The accumulator (bits 31:24 at offset 0x94) increases by one on every frame event and stops at 255.
- R5: A write of data 0 to offset 0x94 clears the accumulator. A write of non-zero data to 0x94 has no effect, and neither does a write to any other offset.
- R6: A clearing write on the same cycle as a frame event leaves the accumulator at 1.
- R7: After a frame event, bits 11:0 at offset 0x98 hold the largest `fifo_level` seen on any cycle since the previous event, the event cycle included.
- R8: The line count increases on each cycle where both `pix_tick` and `line_valid` are high, and returns to 0 while `line_valid` is low. After a frame event, bits 30:16 at offset 0x9C hold the largest line count reached since the previous event, including a count made on the event cycle.
- R9: Offsets are 0x90 (interval), 0x94 (accumulator and live counter), 0x98 (FIFO peak) and 0x9C (pixel peak). Unused bits and every other offset read as 0. Reads are combinational from the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| frame_evt | input | 1 | Frame boundary event (frame done or vsync) |
| line_valid | input | 1 | High while a line is being received |
| pix_tick | input | 1 | Pixel clock qualifier |
| fifo_level | input | FIFO_W | Current capture FIFO occupancy |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
A counter that slips by one tick shows on the live field in the very next cycle it is read, and it shows in the interval field after the next frame event. A peak tracker that drops its event-cycle sample, or fails to restart, stays hidden until a frame event publishes the peak; it then shows in the first read after that edge. Faults in the accumulator's clear priority or saturation appear one cycle after the write or the 256th event, so the directed cases place reads right there.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int unsigned REG_ADDR_W = 8;
  localparam int unsigned REG_DATA_W = 32;

  localparam logic [REG_ADDR_W-1:0] OFS_INTERVAL = 8'h90;
  localparam logic [REG_ADDR_W-1:0] OFS_ACC_LIVE = 8'h94;
  localparam logic [REG_ADDR_W-1:0] OFS_FIFO_PK  = 8'h98;
  localparam logic [REG_ADDR_W-1:0] OFS_PIX_PK   = 8'h9C;

  localparam int unsigned ACC_LSB = 24;
  localparam int unsigned PIX_LSB = 16;
endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfs_interval_ctr.sv
module cfs_interval_ctr #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             frame_evt,
  input  logic             acc_clr,
  output logic [CNT_W-1:0] live_q,
  output logic [CNT_W-1:0] interval_q,
  output logic [ACC_W-1:0] acc_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
  localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] live_d;
  logic             live_en;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  always_comb begin
    live_en = frame_evt | (ref_tick & (live_q != CNT_MAX));
    live_d  = frame_evt ? '0 : live_q + 1'b1;
  end

  always_comb begin
    acc_en = 1'b1;
    if (frame_evt && acc_clr)    acc_d = ACC_ONE;
    else if (acc_clr)            acc_d = '0;
    else if (frame_evt && (acc_q != ACC_MAX)) acc_d = acc_q + 1'b1;
    else begin
      acc_d  = acc_q;
      acc_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (live_en) live_q <= live_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         interval_q <= '0;
    else if (frame_evt) interval_q <= live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/cfs_peak_hold.sv
module cfs_peak_hold #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_evt,
  input  logic [W-1:0] smp,
  output logic [W-1:0] run_q,
  output logic [W-1:0] held_q
);
  logic [W-1:0] peak;
  logic [W-1:0] run_d;

  always_comb begin
    peak  = (smp > run_q) ? smp : run_q;
    run_d = frame_evt ? '0 : peak;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held_q <= '0;
    else if (frame_evt) held_q <= peak;
  end
endmodule

// File: rtl/cfs_line_ctr.sv
module cfs_line_ctr #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_valid,
  input  logic         pix_tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_comb begin
    if (!line_valid)                        cnt_d = '0;
    else if (pix_tick && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    else                                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfs_reg_read.sv
module cfs_reg_read
  import cfs_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ACC_W  = 8,
  parameter int unsigned FIFO_W = 12,
  parameter int unsigned PIX_W  = 15
) (
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]      interval,
  input  logic [CNT_W-1:0]      live,
  input  logic [ACC_W-1:0]      acc,
  input  logic [FIFO_W-1:0]     fifo_pk,
  input  logic [PIX_W-1:0]      pix_pk,
  output logic [REG_DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_INTERVAL: rdata[CNT_W-1:0] = interval;
      OFS_ACC_LIVE: begin
        rdata[CNT_W-1:0]           = live;
        rdata[ACC_LSB +: ACC_W]    = acc;
      end
      OFS_FIFO_PK:  rdata[FIFO_W-1:0] = fifo_pk;
      OFS_PIX_PK:   rdata[PIX_LSB +: PIX_W] = pix_pk;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/cam_frame_stats.sv
module cam_frame_stats
  import cfs_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ACC_W  = 8,
  parameter int unsigned FIFO_W = 12,
  parameter int unsigned PIX_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              frame_evt,
  input  logic              line_valid,
  input  logic              pix_tick,
  input  logic [FIFO_W-1:0] fifo_level,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic              rst_q_n;
  logic              acc_clr;
  logic [CNT_W-1:0]  live_cnt;
  logic [CNT_W-1:0]  interval;
  logic [ACC_W-1:0]  acc;
  logic [FIFO_W-1:0] fifo_run;
  logic [FIFO_W-1:0] fifo_pk;
  logic [PIX_W-1:0]  line_cnt;
  logic [PIX_W-1:0]  line_cnt_d;
  logic [PIX_W-1:0]  pix_run;
  logic [PIX_W-1:0]  pix_pk;

  assign acc_clr = reg_wr && (reg_addr == OFS_ACC_LIVE) && (reg_wdata == '0);

  cfs_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  cfs_interval_ctr #(.CNT_W(CNT_W), .ACC_W(ACC_W)) ival_i (
    .clk(clk), .rst_n(rst_q_n), .ref_tick(ref_tick), .frame_evt(frame_evt),
    .acc_clr(acc_clr), .live_q(live_cnt), .interval_q(interval), .acc_q(acc)
  );

  cfs_peak_hold #(.W(FIFO_W)) fifo_pk_i (
    .clk(clk), .rst_n(rst_q_n), .frame_evt(frame_evt), .smp(fifo_level),
    .run_q(fifo_run), .held_q(fifo_pk)
  );

  cfs_line_ctr #(.W(PIX_W)) line_i (
    .clk(clk), .rst_n(rst_q_n), .line_valid(line_valid), .pix_tick(pix_tick),
    .cnt_q(line_cnt), .cnt_d(line_cnt_d)
  );

  cfs_peak_hold #(.W(PIX_W)) pix_pk_i (
    .clk(clk), .rst_n(rst_q_n), .frame_evt(frame_evt), .smp(line_cnt_d),
    .run_q(pix_run), .held_q(pix_pk)
  );

  cfs_reg_read #(.CNT_W(CNT_W), .ACC_W(ACC_W), .FIFO_W(FIFO_W), .PIX_W(PIX_W)) rd_i (
    .addr(reg_addr), .interval(interval), .live(live_cnt), .acc(acc),
    .fifo_pk(fifo_pk), .pix_pk(pix_pk), .rdata(reg_rdata)
  );
endmodule

// File: rtl/cam_frame_stats_chk.sv
module cam_frame_stats_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ACC_W  = 8,
  parameter int unsigned FIFO_W = 12,
  parameter int unsigned PIX_W  = 15
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              ref_tick,
  input logic              frame_evt,
  input logic              line_valid,
  input logic              reg_wr,
  input logic [7:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [FIFO_W-1:0] fifo_level,
  input logic [CNT_W-1:0]  live_cnt,
  input logic [CNT_W-1:0]  interval,
  input logic [ACC_W-1:0]  acc,
  input logic [FIFO_W-1:0] fifo_run,
  input logic [PIX_W-1:0]  line_cnt
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == 8'h94) && (reg_wdata == 32'd0);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!frame_evt && ref_tick && (live_cnt != {CNT_W{1'b1}})) |=> (live_cnt == $past(live_cnt) + 1'b1));

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!frame_evt && !ref_tick) |=> $stable(live_cnt));

  assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_evt |=> (live_cnt == '0));

  assert_interval_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_evt |=> (interval == $past(live_cnt)));

  assert_acc_clear_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!frame_evt && clr_wr) |=> (acc == '0));

  assert_acc_both_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (frame_evt && clr_wr) |=> (acc == {{(ACC_W-1){1'b0}}, 1'b1}));

  assert_fifo_peak_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !frame_evt |=> (fifo_run >= $past(fifo_level)));

  assert_line_reset_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !line_valid |=> (line_cnt == '0));
endmodule

bind cam_frame_stats cam_frame_stats_chk #(
  .CNT_W(CNT_W), .ACC_W(ACC_W), .FIFO_W(FIFO_W), .PIX_W(PIX_W)
) chk_i (
  .clk(clk), .rst_q_n(rst_q_n), .ref_tick(ref_tick), .frame_evt(frame_evt),
  .line_valid(line_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fifo_level(fifo_level), .live_cnt(live_cnt),
  .interval(interval), .acc(acc), .fifo_run(fifo_run), .line_cnt(line_cnt)
);

// File: tb/cam_frame_stats_tb_top.sv
module cam_frame_stats_tb_top;
  localparam int CW = 10;
  localparam int AW = 8;
  localparam int FW = 12;
  localparam int PW = 15;

  logic clk;
  logic rst_n;
  logic ref_tick, frame_evt, line_valid, pix_tick, reg_wr;
  logic [FW-1:0] fifo_level;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int unsigned m_live, m_ival, m_acc, m_frun, m_fpk, m_line, m_prun, m_ppk;

  cam_frame_stats #(.CNT_W(CW), .ACC_W(AW), .FIFO_W(FW), .PIX_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .frame_evt(frame_evt),
    .line_valid(line_valid), .pix_tick(pix_tick), .fifo_level(fifo_level),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h90:   return 32'(m_ival);
      8'h94:   return (32'(m_acc) << 24) | 32'(m_live);
      8'h98:   return 32'(m_fpk);
      8'h9C:   return 32'(m_ppk) << 16;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h90:   return "R3";
      8'h94:   return "R2/R4";
      8'h98:   return "R7";
      8'h9C:   return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int unsigned umax(input int unsigned x, input int unsigned y);
    return (x > y) ? x : y;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, reg_addr, act, exp);
    end
  endtask

  // Model update at a clock edge from the inputs of that cycle.
  task automatic model_step(input bit ev, input bit tk, input bit lv, input bit pt,
                            input int unsigned fl, input bit clr);
    int unsigned lnext;
    lnext = !lv ? 0 : ((pt && m_line != (1 << PW) - 1) ? m_line + 1 : m_line);
    if (ev) begin
      m_ival = m_live;
      m_live = 0;
      m_fpk  = umax(m_frun, fl);
      m_frun = 0;
      m_ppk  = umax(m_prun, lnext);
      m_prun = 0;
    end else begin
      if (tk && m_live != (1 << CW) - 1) m_live = m_live + 1;
      m_frun = umax(m_frun, fl);
      m_prun = umax(m_prun, lnext);
    end
    if (ev && clr)                          m_acc = 1;
    else if (clr)                           m_acc = 0;
    else if (ev && m_acc != (1 << AW) - 1)  m_acc = m_acc + 1;
    m_line = lnext;
  endtask

  // Entered and left at a negedge; the read at addr is checked one cycle later.
  task automatic cyc(input bit ev, input bit tk, input bit lv, input bit pt,
                     input int unsigned fl, input bit wr, input logic [7:0] addr,
                     input logic [31:0] wd, input string tag);
    frame_evt = ev; ref_tick = tk; line_valid = lv; pix_tick = pt;
    fifo_level = FW'(fl); reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    @(posedge clk);
    model_step(ev, tk, lv, pt, fl, wr && addr == 8'h94 && wd == 0);
    @(negedge clk);
    reg_wr = 1'b0;
    check(tag, reg_rdata, exp_read(addr));
  endtask

  task automatic rd(input logic [7:0] addr, input string tag);
    cyc(0, 0, 0, 0, 0, 0, addr, 0, tag);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit lv;
    void'($urandom(32'd5150));
    m_live = 0; m_ival = 0; m_acc = 0; m_frun = 0; m_fpk = 0;
    m_line = 0; m_prun = 0; m_ppk = 0;
    rst_n = 1'b0; ref_tick = 0; frame_evt = 0; line_valid = 0; pix_tick = 0;
    fifo_level = '0; reg_wr = 0; reg_addr = 8'h00; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state on every register
    rd(8'h90, "R1"); rd(8'h94, "R1"); rd(8'h98, "R1"); rd(8'h9C, "R1");

    // R2: counting and holding
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 0, 8'h94, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 8'h94, 0, "R2");
    // R3: event with a tick on the same cycle still restarts at 0
    cyc(1, 1, 0, 0, 0, 0, 8'h90, 0, "R3");
    rd(8'h94, "R3");

    // R7 and R8: peaks including a sample made on the event cycle
    cyc(0, 0, 1, 1, 100, 0, 8'h98, 0, "R7");
    cyc(0, 0, 1, 1, 40, 0, 8'h98, 0, "R7");
    cyc(0, 0, 0, 0, 7, 0, 8'h9C, 0, "R8");
    cyc(0, 0, 1, 1, 0, 0, 8'h9C, 0, "R8");
    cyc(0, 0, 1, 1, 0, 0, 8'h9C, 0, "R8");
    cyc(1, 0, 1, 1, 3000, 0, 8'h98, 0, "R7");
    rd(8'h9C, "R8");
    // next frame restarts the peaks
    cyc(1, 0, 0, 0, 5, 0, 8'h98, 0, "R7");
    rd(8'h9C, "R8");

    // R5: ignored writes, then a clearing write
    cyc(0, 0, 0, 0, 0, 1, 8'h94, 32'h0000_0001, "R5");
    cyc(0, 0, 0, 0, 0, 1, 8'h98, 32'h0, "R5");
    rd(8'h94, "R5");
    cyc(0, 0, 0, 0, 0, 1, 8'h94, 32'h0, "R5");
    // R6: clear together with an event
    cyc(1, 0, 0, 0, 0, 0, 8'h94, 0, "R6");
    cyc(1, 0, 0, 0, 0, 1, 8'h94, 32'h0, "R6");

    // R4: accumulator saturation
    for (int i = 0; i < 260; i++) cyc(1, 0, 0, 0, 0, 0, 8'h94, 0, "R4");

    // R2: live counter saturation (CW bits in this bench)
    for (int i = 0; i < (1 << CW) + 20; i++) cyc(0, 1, 0, 0, 0, 0, 8'h94, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, 8'h90, 0, "R3");

    // R9: unmapped offsets
    rd(8'h00, "R9"); rd(8'h8C, "R9"); rd(8'hA0, "R9"); rd(8'h95, "R9");

    // constrained random mix
    lv = 0;
    for (int i = 0; i < 4000; i++) begin
      bit ev, tk, pt, wr;
      logic [7:0] a;
      logic [31:0] wd;
      int unsigned pick;
      ev = ($urandom_range(0, 47) == 0);
      tk = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) lv = !lv;
      pt = $urandom_range(0, 2) != 0;
      wr = ($urandom_range(0, 29) == 0);
      wd = ($urandom_range(0, 1) == 1) ? 32'd0 : $urandom;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = 8'h90;
        1, 2: a = 8'h94;
        3: a = 8'h98;
        4: a = 8'h9C;
        default: a = 8'($urandom);
      endcase
      cyc(ev, tk, lv, pt, $urandom_range(0, (1 << FW) - 1), wr,
          wr ? 8'h94 : a, wd, tag_of(wr ? 8'h94 : a));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule